// File: doc/BRIEF.md
# Pager Power State and Reference Timer

This block decides whether the pager decoder is awake. The decoder is ON when an external wake pin is high or when a software-owned enable bit is set. It is OFF only when both are low. While ON, the receiver-enable and oscillator-enable requests from the synchronisation logic, and the serial receive data, pass through to the call-processing side. While OFF, the block holds those outputs low, so incoming data has no effect downstream.

The block also drives a free-running reference output whose rate is chosen by a 2-bit select. The rates are the base rate, 50 Hz, 2 Hz and 1/60 Hz. The output runs in both power states. The block is clocked at twice the base reference rate (65.536 kHz for a 32.768 kHz base), so every rate, including the base one, comes from a register toggle.

The 50 Hz rate is not an integer division of the clock. It comes from a phase accumulator that is exact on average. The two slow rates come from a chained pair of modulo counters. When the select changes, the whole divider chain restarts from zero with the output low. A synchronous active-high reset clears the enable bit and all dividers.

Top module: `pgr_pwr_ref`

## Requirements
- R1: `state_on_o` equals (`wake_pin_i` OR enable bit), taken from the values before the clock edge, and appears one clock later.
- R2: When ON, `rx_en_o`, `osc_en_o` and `dat_o` equal `rx_req_i`, `osc_req_i` and `dat_i` from the previous clock.
- R3: When OFF, `rx_en_o` and `osc_en_o` are 0 and `dat_o` is all zeros, whatever the requests and the data.
- R4: The enable bit takes `en_val_i` on a clock where `en_wr_i` is 1 and otherwise keeps its value. Reset clears it to 0. The new value first affects `state_on_o` one clock after the write edge.
- R5: Select 0 (base rate): `ref_o` toggles on every clock.
- R6: Select 1 (50 Hz): an accumulator adds FRAC_STEP modulo 2^FRAC_W on every clock, and `ref_o` toggles on the edge where it wraps. After a restart, exactly floor(FRAC_STEP*n / 2^FRAC_W) toggles occur in n clocks.
- R7: Select 2 (2 Hz): `ref_o` toggles once every MID_HALF clocks.
- R8: Select 3 (1/60 Hz): `ref_o` toggles once every MID_HALF*SLOW_HALVES clocks, so high and low phases are equal.
- R9: On a clock edge where `rate_sel_i` differs from the select in use, the new select is taken, `ref_o` goes to 0 and every divider counter restarts from zero.
- R10: While `rst` is high at a clock edge, all outputs go to 0, the enable bit clears and the select in use is loaded from `rate_sel_i`.
- R11: `ref_o` keeps running while the decoder is OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the base reference rate |
| rst | input | 1 | Synchronous active-high reset |
| wake_pin_i | input | 1 | Direct wake control pin |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_val_i | input | 1 | Value written to the enable bit |
| rate_sel_i | input | 2 | Reference rate: 0 base, 1 50 Hz, 2 2 Hz, 3 1/60 Hz |
| rx_req_i | input | 1 | Receiver-enable request from the sync logic |
| osc_req_i | input | 1 | Oscillator-enable request from the sync logic |
| dat_i | input | DAT_W | Serial receive data |
| state_on_o | output | 1 | Current operating state (1 = ON) |
| rx_en_o | output | 1 | Gated receiver enable |
| osc_en_o | output | 1 | Gated oscillator enable |
| dat_o | output | DAT_W | Gated data toward call processing |
| ref_o | output | 1 | Timing reference output |

## Verification
The bench builds the block with FRAC_W=8, FRAC_STEP=24, MID_HALF=12 and SLOW_HALVES=5. With these values the 1/60 Hz mode completes a full period in 120 clocks, and the accumulator wraps every few clocks. A step of 24 does not divide 256, so the one-clock jitter of the fractional mode shows up and the exact toggle count over 256 clocks can be checked. The short counter periods also let select changes land in the middle of a count, so the restart is tested against partly advanced dividers in every mode.

// File: rtl/pgr_ref_pkg.sv
package pgr_ref_pkg;
  typedef enum logic [1:0] {
    RATE_BASE = 2'd0,
    RATE_FRAC = 2'd1,
    RATE_MID  = 2'd2,
    RATE_SLOW = 2'd3
  } rate_e;
endpackage

// File: rtl/pgr_pwr_gate.sv
module pgr_pwr_gate #(
  parameter int DAT_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wake_pin_i,
  input  logic             en_wr_i,
  input  logic             en_val_i,
  input  logic             rx_req_i,
  input  logic             osc_req_i,
  input  logic [DAT_W-1:0] dat_i,
  output logic             state_on_o,
  output logic             rx_en_o,
  output logic             osc_en_o,
  output logic [DAT_W-1:0] dat_o
);
  logic en_bit_q;
  logic on_now;

  // Awake when either the pin or the stored bit asks for it
  assign on_now = wake_pin_i | en_bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_bit_q <= 1'b0;
    end else if (en_wr_i) begin
      en_bit_q <= en_val_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_on_o <= 1'b0;
      rx_en_o    <= 1'b0;
      osc_en_o   <= 1'b0;
      dat_o      <= '0;
    end else begin
      state_on_o <= on_now;
      rx_en_o    <= on_now & rx_req_i;
      osc_en_o   <= on_now & osc_req_i;
      dat_o      <= on_now ? dat_i : '0;
    end
  end
endmodule

// File: rtl/pgr_mod_tick.sv
module pgr_mod_tick #(
  parameter int MOD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic wrap_o
);
  localparam int CNT_W = (MOD > 1) ? $clog2(MOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MOD - 1);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = adv && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pgr_frac_tick.sv
module pgr_frac_tick #(
  parameter int FRAC_W    = 16,
  parameter int FRAC_STEP = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic carry_o
);
  localparam logic [FRAC_W:0] STEP_V = (FRAC_W + 1)'(FRAC_STEP);

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + STEP_V;
  assign carry_o = adv & sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
    end else if (adv) begin
      acc_q <= sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/pgr_pwr_ref.sv
module pgr_pwr_ref
  import pgr_ref_pkg::*;
#(
  parameter int DAT_W       = 1,
  parameter int FRAC_W      = 16,
  parameter int FRAC_STEP   = 100,
  parameter int MID_HALF    = 16384,
  parameter int SLOW_HALVES = 120
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wake_pin_i,
  input  logic             en_wr_i,
  input  logic             en_val_i,
  input  logic [1:0]       rate_sel_i,
  input  logic             rx_req_i,
  input  logic             osc_req_i,
  input  logic [DAT_W-1:0] dat_i,
  output logic             state_on_o,
  output logic             rx_en_o,
  output logic             osc_en_o,
  output logic [DAT_W-1:0] dat_o,
  output logic             ref_o
);
  rate_e sel_q;
  rate_e sel_new;
  logic  sel_chg;
  logic  run;
  logic  frac_c;
  logic  mid_w;
  logic  slow_w;
  logic  mid_adv;
  logic  slow_adv;
  logic  frac_adv;

  pgr_pwr_gate #(.DAT_W(DAT_W)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .wake_pin_i (wake_pin_i),
    .en_wr_i    (en_wr_i),
    .en_val_i   (en_val_i),
    .rx_req_i   (rx_req_i),
    .osc_req_i  (osc_req_i),
    .dat_i      (dat_i),
    .state_on_o (state_on_o),
    .rx_en_o    (rx_en_o),
    .osc_en_o   (osc_en_o),
    .dat_o      (dat_o)
  );

  assign sel_new  = rate_e'(rate_sel_i);
  assign sel_chg  = (sel_new != sel_q);
  assign run      = !sel_chg;
  assign frac_adv = run && (sel_q == RATE_FRAC);
  assign mid_adv  = run && ((sel_q == RATE_MID) || (sel_q == RATE_SLOW));
  assign slow_adv = mid_w && (sel_q == RATE_SLOW);

  pgr_frac_tick #(.FRAC_W(FRAC_W), .FRAC_STEP(FRAC_STEP)) u_frac (
    .clk     (clk),
    .rst     (rst),
    .clr     (sel_chg),
    .adv     (frac_adv),
    .carry_o (frac_c)
  );

  pgr_mod_tick #(.MOD(MID_HALF)) u_mid (
    .clk    (clk),
    .rst    (rst),
    .clr    (sel_chg),
    .adv    (mid_adv),
    .wrap_o (mid_w)
  );

  pgr_mod_tick #(.MOD(SLOW_HALVES)) u_slow (
    .clk    (clk),
    .rst    (rst),
    .clr    (sel_chg),
    .adv    (slow_adv),
    .wrap_o (slow_w)
  );

  // Output toggle register: restart on select change, otherwise toggle on the tick of the mode in use
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= sel_new;
      ref_o <= 1'b0;
    end else if (sel_chg) begin
      sel_q <= sel_new;
      ref_o <= 1'b0;
    end else begin
      unique case (sel_q)
        RATE_BASE: ref_o <= ~ref_o;
        RATE_FRAC: if (frac_c) ref_o <= ~ref_o;
        RATE_MID:  if (mid_w)  ref_o <= ~ref_o;
        RATE_SLOW: if (slow_w) ref_o <= ~ref_o;
        default:   ref_o <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pgr_pwr_ref_chk.sv
module pgr_pwr_ref_chk #(
  parameter int DAT_W = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wake_pin_i,
  input logic [1:0]       rate_sel_i,
  input logic             rx_req_i,
  input logic [1:0]       sel_q,
  input logic             state_on_o,
  input logic             rx_en_o,
  input logic             osc_en_o,
  input logic [DAT_W-1:0] dat_o,
  input logic             ref_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!ref_o && !state_on_o && !rx_en_o && !osc_en_o)); // R10

  AST_PIN_WAKES: assert property (@(posedge clk) disable iff (rst)
    wake_pin_i |=> state_on_o); // R1

  AST_ON_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    wake_pin_i |=> (rx_en_o == $past(rx_req_i))); // R2

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !state_on_o |-> (!rx_en_o && !osc_en_o && (dat_o == '0))); // R3

  AST_BASE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    ((sel_q == 2'd0) && (rate_sel_i == 2'd0)) |=> (ref_o != $past(ref_o))); // R5

  AST_SEL_RESTART: assert property (@(posedge clk) disable iff (rst)
    (rate_sel_i != sel_q) |=> !ref_o); // R9
endmodule

bind pgr_pwr_ref pgr_pwr_ref_chk #(.DAT_W(DAT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wake_pin_i (wake_pin_i),
  .rate_sel_i (rate_sel_i),
  .rx_req_i   (rx_req_i),
  .sel_q      (sel_q),
  .state_on_o (state_on_o),
  .rx_en_o    (rx_en_o),
  .osc_en_o   (osc_en_o),
  .dat_o      (dat_o),
  .ref_o      (ref_o)
);

// File: tb/pgr_pwr_ref_tb.sv
module pgr_pwr_ref_tb;
  localparam int DW    = 1;
  localparam int FW    = 8;
  localparam int STEP  = 24;
  localparam int MIDH  = 12;
  localparam int SLOWH = 5;
  localparam int MODV  = 1 << FW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wake_pin = 1'b0;
  logic en_wr = 1'b0;
  logic en_val = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic rx_req = 1'b0;
  logic osc_req = 1'b0;
  logic [DW-1:0] dat = '0;
  logic state_on, rx_en, osc_en, ref_out;
  logic [DW-1:0] dat_out;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;

  // reference model state
  int m_bit, m_on, m_rx, m_osc, m_dat, m_sel, m_acc, m_mid, m_slow, m_ref;
  bit m_restart, m_inrst;

  always #2.5 clk = ~clk;

  pgr_pwr_ref #(
    .DAT_W(DW), .FRAC_W(FW), .FRAC_STEP(STEP),
    .MID_HALF(MIDH), .SLOW_HALVES(SLOWH)
  ) u_dut (
    .clk(clk), .rst(rst), .wake_pin_i(wake_pin), .en_wr_i(en_wr),
    .en_val_i(en_val), .rate_sel_i(rate_sel), .rx_req_i(rx_req),
    .osc_req_i(osc_req), .dat_i(dat), .state_on_o(state_on),
    .rx_en_o(rx_en), .osc_en_o(osc_en), .dat_o(dat_out), .ref_o(ref_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // Behavioural model, advanced on each rising edge from the inputs held there
  always @(posedge clk) begin
    m_restart = 1'b0;
    m_inrst   = rst;
    if (rst) begin
      m_bit = 0; m_on = 0; m_rx = 0; m_osc = 0; m_dat = 0;
      m_sel = rate_sel; m_acc = 0; m_mid = 0; m_slow = 0; m_ref = 0;
    end else begin
      int on;
      on    = (wake_pin || m_bit != 0) ? 1 : 0;
      m_on  = on;
      m_rx  = on & rx_req;
      m_osc = on & osc_req;
      m_dat = on ? int'(dat) : 0;
      if (en_wr) m_bit = en_val;
      if (int'(rate_sel) != m_sel) begin
        m_sel = rate_sel; m_acc = 0; m_mid = 0; m_slow = 0; m_ref = 0;
        m_restart = 1'b1;
      end else begin
        case (m_sel)
          0: m_ref = 1 - m_ref;
          1: begin
            m_acc = m_acc + STEP;
            if (m_acc >= MODV) begin m_acc = m_acc - MODV; m_ref = 1 - m_ref; end
          end
          2: begin
            m_mid++;
            if (m_mid == MIDH) begin m_mid = 0; m_ref = 1 - m_ref; end
          end
          default: begin
            m_mid++;
            if (m_mid == MIDH) begin
              m_mid = 0; m_slow++;
              if (m_slow == SLOWH) begin m_slow = 0; m_ref = 1 - m_ref; end
            end
          end
        endcase
      end
    end
  end

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      string rtag;
      if (m_inrst) rtag = "R10";
      else if (m_restart) rtag = "R9";
      else case (m_sel)
        0: rtag = "R5";
        1: rtag = "R6";
        2: rtag = "R7";
        default: rtag = "R8";
      endcase
      chk(m_inrst ? "R10" : "R1", int'(state_on), m_on);
      chk(m_on != 0 ? "R2" : "R3", int'(rx_en), m_rx);
      chk(m_on != 0 ? "R2" : "R3", int'(osc_en), m_osc);
      chk(m_on != 0 ? "R2" : "R3", int'(dat_out), m_dat);
      chk(rtag, int'(ref_out), m_ref);
    end
  end

  task automatic cycles(input int n, input bit rnd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rnd) begin
        rx_req  = 1'($urandom);
        osc_req = 1'($urandom);
        dat     = DW'($urandom);
      end
    end
  endtask

  task automatic write_bit(input bit v);
    @(negedge clk);
    en_wr = 1'b1; en_val = v;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int toggles;
    logic prev;
    cmp_en = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", int'(state_on | rx_en | osc_en | ref_out), 0);
    rst = 1'b0;

    // R3 and R11: OFF, data and requests must be blocked while ref runs
    cycles(20, 1'b1);
    prev = ref_out; toggles = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ref_out != prev) toggles++;
      prev = ref_out;
    end
    chk("R11", toggles, 10);
    chk("R3", int'(state_on), 0);

    // R2: wake via pin
    wake_pin = 1'b1;
    cycles(20, 1'b1);
    wake_pin = 1'b0;
    cycles(5, 1'b1);

    // R4: wake via stored bit, then clear it
    write_bit(1'b1);
    cycles(15, 1'b1);
    chk("R4", int'(state_on), 1);
    write_bit(1'b0);
    cycles(3, 1'b1);
    chk("R4", int'(state_on), 0);

    // R6: exact toggle count over 256 clocks after restart into select 1
    @(negedge clk); rate_sel = 2'd1;
    @(negedge clk);
    prev = ref_out; toggles = 0;
    for (int i = 0; i < MODV; i++) begin
      @(negedge clk);
      if (ref_out != prev) toggles++;
      prev = ref_out;
    end
    chk("R6", toggles, STEP);

    // R7, R8 and R9: slow modes, with select changes mid-count
    rate_sel = 2'd2; cycles(50, 1'b1);
    rate_sel = 2'd3; cycles(130, 1'b1);
    rate_sel = 2'd2; cycles(7, 1'b0);
    rate_sel = 2'd3; cycles(250, 1'b1);
    rate_sel = 2'd1; cycles(20, 1'b0);
    rate_sel = 2'd0; cycles(10, 1'b0);

    // R4 and R10: reset mid-run clears the stored bit
    write_bit(1'b1);
    rate_sel = 2'd3;
    cycles(30, 1'b1);
    rst = 1'b1; cycles(2, 1'b0);
    rst = 1'b0; cycles(2, 1'b1);
    chk("R4", int'(state_on), 0);
    cycles(100, 1'b1);

    cmp_en = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule